// File: doc/BRIEF.md
# DDC/CI Get-Feature Host Framer

The block runs the host side of one monitor-control query. A one-cycle `go` pulse carries an 8-bit feature code. The block latches that code and forms a six-byte Get VCP Feature request. It hands the request, one byte at a time, to an external I2C master over a byte-operation stream. It then waits a programmable idle gap and opens a separate read message to the display. It collects the eleven reply bytes and checks their framing, length byte, opcode, echoed feature code and checksum. A good reply is reported through `done` and the decoded fields. Any fault is reported through `err` and a cause code.

The master is modelled only as byte-level events. Every operation the block offers on the `m_*` stream is a single beat under valid/ready. Each kind of beat means the following:

- **Write beat:** one byte is written, with an optional start before it and an optional stop after it.
- **Read beat:** one byte is read. The `m_last` flag means the host NACKs that byte and then sends a stop.
- **Stop beat:** a bare stop condition.

Once `m_valid` is high, it stays high and every `m_*` field stays unchanged until the cycle `m_ready` is seen high. The master returns exactly one beat on the `s_*` stream for every accepted operation. The block holds `s_ready` high only while it is waiting for that beat. Only one operation is ever outstanding, so either side may stall for any number of cycles.

Top module: `ddc_host_framer`

## Requirements
- R1: After reset `busy`, `done`, `err`, `m_valid` and `s_ready` are 0, and `err_code`, `max_val` and `cur_val` are 0.
- R2: The request is six write beats carrying 0x6E, 0x51, 0x82, 0x01, the feature latched at `go`, and a checksum. The checksum is the XOR of the first five bytes. Only the first beat has `m_start`=1 and only the sixth has `m_stop`=1. Write beats use `m_kind`=0.
- R3: A beat on `m_*` stays offered, with stable fields, until `m_ready`. No new operation is offered before the response to the previous one is accepted. Each side may stall at any point.
- R4: The read address beat is not offered until more than `gap_cycles` rising clock edges after the edge that accepts the response to the sixth request byte.
- R5: The read message is one write beat of 0x6F with `m_start`=1, followed by eleven read beats (`m_kind`=1). Only the eleventh read beat has `m_last`=1 and `m_stop`=1.
- R6: A reply passes when all of these hold:
  - byte 0 is 0x6E;
  - byte 1 is 0x88;
  - byte 2 is 0x02;
  - byte 4 equals the requested feature;
  - byte 10 equals 0x50 XORed with bytes 0 to 9.

  On a passing reply, `done` pulses for one cycle. In the same cycle the outputs take these values: `res_code`=byte 3, `feat_echo`=byte 4, `type_code`=byte 5, `max_val`={byte 6, byte 7} and `cur_val`={byte 8, byte 9}. `err_code` is 0.
- R7: A nonzero result code in byte 3 is reported through `res_code` with `done`. It is not treated as a fault.
- R8: A failing reply pulses `err` for one cycle, and `err_code` gives the first failing check. The checks are tried in this order: 2 for byte 0, 3 for the length byte, 4 for the opcode, 5 for the feature echo, and 6 for the checksum. The value outputs keep their previous contents.
- R9: If the response to any write beat has `s_nack`=1, no read beat follows and `err` pulses with `err_code`=1. When the NACKed beat did not itself carry a stop, a stop beat (`m_kind`=2) is offered first.
- R10: `busy` rises in the cycle after an accepted `go` and falls in the cycle that `done` or `err` pulses. A `go` that arrives while `busy` is high has no effect, and its feature code is not used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse; accepted only when not busy |
| feature | input | 8 | Feature code sampled with `go` |
| gap_cycles | input | GAP_W | Idle cycles between the write stop and the read start |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse: reply accepted |
| err | output | 1 | One-cycle pulse: transaction failed |
| err_code | output | 3 | Cause of the last completion (0 means none) |
| res_code | output | 8 | Result code of the last good reply |
| feat_echo | output | 8 | Feature code echoed by the last good reply |
| type_code | output | 8 | Type code of the last good reply |
| max_val | output | 16 | Maximum value of the last good reply |
| cur_val | output | 16 | Present value of the last good reply |
| m_valid | output | 1 | Operation beat offered to the master |
| m_ready | input | 1 | Master accepts the beat |
| m_kind | output | 2 | 0 = write byte, 1 = read byte, 2 = stop only |
| m_start | output | 1 | Start condition precedes this byte |
| m_stop | output | 1 | Stop condition follows this operation |
| m_last | output | 1 | Read byte is NACKed (final byte) |
| m_data | output | 8 | Byte to write |
| s_valid | input | 1 | Response beat from the master |
| s_ready | output | 1 | Block waits for a response |
| s_data | input | 8 | Byte read (read beats) |
| s_nack | input | 1 | Target refused a written byte |

## Verification
A wrong byte index or request-generator fault shows up within one beat as a wrong `m_data` or a misplaced start/stop flag on the operation stream. A sequencer that loses its place also shows up quickly. It appears either as a second beat offered while a response is pending, or as a read beat after a refused write. A short gap count is visible as the read address arriving too few edges after the last write response. A reply checker with a bad running XOR or bad field capture only shows at the end of the reply. It appears in the cycle after the eleventh response, as the wrong one of `done`/`err`, the wrong cause code, or field outputs that changed when they should have held.

// File: rtl/ddc_host_pkg.sv
package ddc_host_pkg;
  localparam logic [7:0] BYTE_DST    = 8'h6E;
  localparam logic [7:0] BYTE_SRC    = 8'h51;
  localparam logic [7:0] BYTE_RDADR  = 8'h6F;
  localparam logic [7:0] REQ_LEN     = 8'h82;
  localparam logic [7:0] RPL_LEN     = 8'h88;
  localparam logic [7:0] OPC_GET     = 8'h01;
  localparam logic [7:0] OPC_REPLY   = 8'h02;
  localparam logic [7:0] VIRT_SEED   = 8'h50;

  localparam int REQ_N = 6;
  localparam int RPL_N = 11;
  localparam int IDX_W = $clog2(RPL_N);

  localparam logic [IDX_W-1:0] REQ_LAST = IDX_W'(REQ_N - 1);
  localparam logic [IDX_W-1:0] RPL_LAST = IDX_W'(RPL_N - 1);

  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_RD   = 2'd1,
    OP_STOP = 2'd2
  } op_kind_e;

  typedef enum logic [2:0] {
    F_NONE = 3'd0,
    F_NACK = 3'd1,
    F_SRC  = 3'd2,
    F_LEN  = 3'd3,
    F_OPC  = 3'd4,
    F_FEAT = 3'd5,
    F_CHK  = 3'd6
  } fault_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_REQ,
    S_REQ_RSP,
    S_GAP,
    S_RADR,
    S_RADR_RSP,
    S_RD,
    S_RD_RSP,
    S_ABT,
    S_ABT_RSP
  } phase_e;
endpackage

// File: rtl/ddc_req_gen.sv
module ddc_req_gen
  import ddc_host_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       feat,
  output logic [7:0]       byte_o
);
  logic [7:0] body [REQ_N];
  logic [7:0] sum;

  always_comb begin
    body[0] = BYTE_DST;
    body[1] = BYTE_SRC;
    body[2] = REQ_LEN;
    body[3] = OPC_GET;
    body[4] = feat;
    sum = 8'h00;
    for (int i = 0; i < REQ_N - 1; i++) begin
      sum = sum ^ body[i];
    end
    body[REQ_N-1] = sum;
  end

  always_comb begin
    byte_o = 8'h00;
    for (int i = 0; i < REQ_N; i++) begin
      if (idx == IDX_W'(i)) byte_o = body[i];
    end
  end
endmodule

// File: rtl/ddc_gap_timer.sv
module ddc_gap_timer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  input  logic         run,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= value;
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);

  // R4: the counter never reloads while it is still running down
  assert_gap_noreload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !load);
endmodule

// File: rtl/ddc_reply_check.sv
module ddc_reply_check
  import ddc_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  input  logic [7:0]       want_feat,
  output fault_e           verdict,
  output logic [7:0]       f_rc,
  output logic [7:0]       f_feat,
  output logic [7:0]       f_type,
  output logic [15:0]      f_max,
  output logic [15:0]      f_cur
);
  localparam int BODY_N = RPL_N - 1;

  logic [7:0] held [BODY_N];
  logic [7:0] acc;

  genvar g;
  generate
    for (g = 0; g < BODY_N; g++) begin : g_cap
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          held[g] <= 8'h00;
        end else if (push && idx == IDX_W'(g)) begin
          held[g] <= data;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= VIRT_SEED;
    end else if (clear) begin
      acc <= VIRT_SEED;
    end else if (push) begin
      acc <= acc ^ data;
    end
  end

  // verdict is meaningful while the final (checksum) byte is presented
  always_comb begin
    if (held[0] != BYTE_DST)       verdict = F_SRC;
    else if (held[1] != RPL_LEN)   verdict = F_LEN;
    else if (held[2] != OPC_REPLY) verdict = F_OPC;
    else if (held[4] != want_feat) verdict = F_FEAT;
    else if (data != acc)          verdict = F_CHK;
    else                           verdict = F_NONE;
  end

  assign f_rc   = held[3];
  assign f_feat = held[4];
  assign f_type = held[5];
  assign f_max  = {held[6], held[7]};
  assign f_cur  = {held[8], held[9]};

  // R5: no reply byte beyond the eleventh is ever taken in
  assert_push_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> idx <= RPL_LAST);
endmodule

// File: rtl/ddc_host_framer.sv
module ddc_host_framer
  import ddc_host_pkg::*;
#(
  parameter int GAP_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [7:0]       feature,
  input  logic [GAP_W-1:0] gap_cycles,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [2:0]       err_code,
  output logic [7:0]       res_code,
  output logic [7:0]       feat_echo,
  output logic [7:0]       type_code,
  output logic [15:0]      max_val,
  output logic [15:0]      cur_val,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [1:0]       m_kind,
  output logic             m_start,
  output logic             m_stop,
  output logic             m_last,
  output logic [7:0]       m_data,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_nack
);
  phase_e           phase;
  logic [IDX_W-1:0] idx;
  logic [7:0]       feat_q;
  logic [7:0]       req_byte;
  logic             tmr_load;
  logic             tmr_run;
  logic             tmr_exp;
  logic             chk_push;
  logic             chk_clear;
  fault_e           verdict;
  logic [7:0]       c_rc, c_feat, c_type;
  logic [15:0]      c_max, c_cur;
  logic             rsp_fire;

  ddc_req_gen u_req (
    .idx    (idx),
    .feat   (feat_q),
    .byte_o (req_byte)
  );

  ddc_gap_timer #(.W(GAP_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .value   (gap_cycles),
    .run     (tmr_run),
    .expired (tmr_exp)
  );

  ddc_reply_check u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (chk_clear),
    .push      (chk_push),
    .idx       (idx),
    .data      (s_data),
    .want_feat (feat_q),
    .verdict   (verdict),
    .f_rc      (c_rc),
    .f_feat    (c_feat),
    .f_type    (c_type),
    .f_max     (c_max),
    .f_cur     (c_cur)
  );

  // operation stream, decoded from the phase
  always_comb begin
    m_valid = 1'b0;
    m_kind  = OP_WR;
    m_start = 1'b0;
    m_stop  = 1'b0;
    m_last  = 1'b0;
    m_data  = 8'h00;
    unique case (phase)
      S_REQ: begin
        m_valid = 1'b1;
        m_data  = req_byte;
        m_start = (idx == '0);
        m_stop  = (idx == REQ_LAST);
      end
      S_RADR: begin
        m_valid = 1'b1;
        m_data  = BYTE_RDADR;
        m_start = 1'b1;
      end
      S_RD: begin
        m_valid = 1'b1;
        m_kind  = OP_RD;
        m_last  = (idx == RPL_LAST);
        m_stop  = (idx == RPL_LAST);
      end
      S_ABT: begin
        m_valid = 1'b1;
        m_kind  = OP_STOP;
        m_stop  = 1'b1;
      end
      default: ;
    endcase
  end

  assign s_ready   = (phase == S_REQ_RSP) || (phase == S_RADR_RSP) ||
                     (phase == S_RD_RSP)  || (phase == S_ABT_RSP);
  assign rsp_fire  = s_valid && s_ready;
  assign busy      = (phase != S_IDLE);
  assign tmr_load  = (phase == S_REQ_RSP) && s_valid && !s_nack && (idx == REQ_LAST);
  assign tmr_run   = (phase == S_GAP);
  assign chk_clear = (phase == S_IDLE) && go;
  assign chk_push  = (phase == S_RD_RSP) && s_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= S_IDLE;
      idx       <= '0;
      feat_q    <= 8'h00;
      done      <= 1'b0;
      err       <= 1'b0;
      err_code  <= 3'd0;
      res_code  <= 8'h00;
      feat_echo <= 8'h00;
      type_code <= 8'h00;
      max_val   <= 16'h0000;
      cur_val   <= 16'h0000;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (phase)
        S_IDLE: begin
          if (go) begin
            feat_q <= feature;
            idx    <= '0;
            phase  <= S_REQ;
          end
        end
        S_REQ: if (m_ready) phase <= S_REQ_RSP;
        S_REQ_RSP: begin
          if (rsp_fire) begin
            if (s_nack) begin
              if (idx == REQ_LAST) begin
                phase    <= S_IDLE;
                err      <= 1'b1;
                err_code <= F_NACK;
              end else begin
                phase <= S_ABT;
              end
            end else if (idx == REQ_LAST) begin
              phase <= S_GAP;
            end else begin
              idx   <= idx + 1'b1;
              phase <= S_REQ;
            end
          end
        end
        S_GAP: if (tmr_exp) phase <= S_RADR;
        S_RADR: if (m_ready) phase <= S_RADR_RSP;
        S_RADR_RSP: begin
          if (rsp_fire) begin
            if (s_nack) begin
              phase <= S_ABT;
            end else begin
              idx   <= '0;
              phase <= S_RD;
            end
          end
        end
        S_RD: if (m_ready) phase <= S_RD_RSP;
        S_RD_RSP: begin
          if (rsp_fire) begin
            if (idx == RPL_LAST) begin
              phase    <= S_IDLE;
              err_code <= verdict;
              if (verdict == F_NONE) begin
                done      <= 1'b1;
                res_code  <= c_rc;
                feat_echo <= c_feat;
                type_code <= c_type;
                max_val   <= c_max;
                cur_val   <= c_cur;
              end else begin
                err <= 1'b1;
              end
            end else begin
              idx   <= idx + 1'b1;
              phase <= S_RD;
            end
          end
        end
        S_ABT: if (m_ready) phase <= S_ABT_RSP;
        S_ABT_RSP: begin
          if (rsp_fire) begin
            phase    <= S_IDLE;
            err      <= 1'b1;
            err_code <= F_NACK;
          end
        end
        default: phase <= S_IDLE;
      endcase
    end
  end

  // R3: an offered beat is held with stable fields until accepted
  assert_beat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_kind) &&
                               $stable(m_start) && $stable(m_stop) && $stable(m_last)));

  // R3: a response wait is never overlapped by a new offer
  assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready) |=> (s_ready && !m_valid));

  // R8: a transaction ends in exactly one way
  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R8: value outputs move only together with a done pulse
  assert_vals_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(max_val) && $stable(cur_val) && $stable(res_code)));

  // R10: busy only drops on a completion pulse
  assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || err));

  // R2: a start condition only ever rides on a write beat
  assert_start_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_start) |-> (m_kind == OP_WR));
endmodule

// File: tb/sim_ddc_host_framer.sv
module sim_ddc_host_framer;
  localparam int GW = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          go = 1'b0;
  logic [7:0]    feature = 8'h00;
  logic [GW-1:0] gap_cycles = '0;
  logic          busy, done, err;
  logic [2:0]    err_code;
  logic [7:0]    res_code, feat_echo, type_code;
  logic [15:0]   max_val, cur_val;
  logic          m_valid, m_start, m_stop, m_last;
  logic          m_ready = 1'b0;
  logic [1:0]    m_kind;
  logic [7:0]    m_data;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [7:0]    s_data = 8'h00;
  logic          s_nack = 1'b0;

  ddc_host_framer #(.GAP_W(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .feature(feature), .gap_cycles(gap_cycles),
    .busy(busy), .done(done), .err(err), .err_code(err_code),
    .res_code(res_code), .feat_echo(feat_echo), .type_code(type_code),
    .max_val(max_val), .cur_val(cur_val),
    .m_valid(m_valid), .m_ready(m_ready), .m_kind(m_kind), .m_start(m_start),
    .m_stop(m_stop), .m_last(m_last), .m_data(m_data),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_nack(s_nack)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // ---- slave model state, configured per transaction ----
  logic [7:0] rep [11];
  int   nack_wr = -1;
  bit   nack_ra = 1'b0;
  logic [7:0] wb [8];
  int   nw = 0, nrd = 0;
  bit   flags_bad = 1'b0, last_bad = 1'b0, abort_seen = 1'b0;
  int   t_acc = -1, t_radr = -1;
  int   sd = 1;

  initial begin : slave
    bit       rd_adr;
    bit       req_last;
    bit       nk;
    logic [7:0] rv;
    logic [1:0] kd;
    logic [7:0] dt;
    logic     st, sp, ls;
    @(negedge clk);
    forever begin
      while (!m_valid) @(negedge clk);
      kd = m_kind; dt = m_data; st = m_start; sp = m_stop; ls = m_last;
      rd_adr = 1'b0; req_last = 1'b0; nk = 1'b0; rv = 8'h00;
      if (kd == 2'd0 && st && dt == 8'h6F) begin
        t_radr = cyc;
        rd_adr = 1'b1;
      end
      sd = (sd * 13 + 7) % 17;
      repeat (sd % 3) @(negedge clk);
      m_ready = 1'b1;
      @(negedge clk);
      m_ready = 1'b0;
      if (kd == 2'd0) begin
        if (rd_adr) begin
          nk = nack_ra;
          nrd = 0;
        end else begin
          if (st) nw = 0;
          if (nw < 8) wb[nw] = dt;
          if (st != (nw == 0) || sp != (nw == 5)) flags_bad = 1'b1;
          nk = (nw == nack_wr);
          req_last = (nw == 5);
          nw++;
        end
      end else if (kd == 2'd1) begin
        rv = (nrd < 11) ? rep[nrd] : 8'hEE;
        if ((ls != (nrd == 10)) || (sp != (nrd == 10))) last_bad = 1'b1;
        nrd++;
      end else begin
        abort_seen = 1'b1;
      end
      sd = (sd * 13 + 7) % 17;
      repeat (sd % 3) @(negedge clk);
      s_valid = 1'b1; s_data = rv; s_nack = nk;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0; s_nack = 1'b0;
      if (req_last) t_acc = cyc;
    end
  end

  // ---- scoreboard ----
  typedef struct {
    bit          is_err;
    logic [2:0]  code;
    logic [7:0]  rc, fc, tp;
    logic [15:0] mx, cu;
    string       rq;
  } exp_t;
  exp_t exq[$];
  logic [15:0] good_mx = 16'h0, good_cu = 16'h0;

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && (done || err)) begin
        if (exq.size() == 0) begin
          chk(1'b0, "R10", "unexpected completion", {30'd0, done, err}, 0);
        end else begin
          e = exq.pop_front();
          chk((err == e.is_err) && (done == !e.is_err), e.rq, "outcome done/err",
              {30'd0, done, err}, e.is_err ? 1 : 2);
          chk(err_code == e.code, e.rq, "err_code", err_code, e.code);
          if (!e.is_err) begin
            chk({res_code, feat_echo, type_code} == {e.rc, e.fc, e.tp}, e.rq,
                "rc/feat/type", {8'd0, res_code, feat_echo, type_code}, {8'd0, e.rc, e.fc, e.tp});
            chk({max_val, cur_val} == {e.mx, e.cu}, e.rq, "max/cur",
                {max_val, cur_val}, {e.mx, e.cu});
            good_mx = e.mx; good_cu = e.cu;
          end else begin
            chk({max_val, cur_val} == {good_mx, good_cu}, "R8", "values kept on error",
                {max_val, cur_val}, {good_mx, good_cu});
          end
        end
      end
    end
  end

  task automatic make_rep(input [7:0] f, input [7:0] rc, input [7:0] tp,
                          input [15:0] mx, input [15:0] cu);
    rep[0] = 8'h6E; rep[1] = 8'h88; rep[2] = 8'h02; rep[3] = rc; rep[4] = f;
    rep[5] = tp; rep[6] = mx[15:8]; rep[7] = mx[7:0]; rep[8] = cu[15:8]; rep[9] = cu[7:0];
  endtask

  task automatic fix_sum();
    logic [7:0] s;
    s = 8'h50;
    for (int i = 0; i < 10; i++) s = s ^ rep[i];
    rep[10] = s;
  endtask

  task automatic run_txn(input [7:0] f, input int gap, input int nwr, input bit nra,
                         input bit expect_err, input [2:0] code, input string rq,
                         input bit poke);
    exp_t e;
    logic [7:0] ex [6];
    int n;
    int nexp;
    e.is_err = expect_err; e.code = code; e.rc = rep[3]; e.fc = rep[4]; e.tp = rep[5];
    e.mx = {rep[6], rep[7]}; e.cu = {rep[8], rep[9]}; e.rq = rq;
    nack_wr = nwr; nack_ra = nra; nw = 0; nrd = 0;
    flags_bad = 1'b0; last_bad = 1'b0; abort_seen = 1'b0; t_acc = -1; t_radr = -1;
    gap_cycles = GW'(gap);
    exq.push_back(e);
    @(negedge clk);
    feature = f; go = 1'b1;
    @(negedge clk);
    go = 1'b0; feature = ~f;
    chk(busy == 1'b1, "R10", "busy after go", {31'd0, busy}, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      feature = f ^ 8'h5A; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
    end
    n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(!busy, "R3", "transaction completes", {31'd0, busy}, 0);
    repeat (4) @(negedge clk);
    chk(exq.size() == 0, rq, "completion seen", exq.size(), 0);
    ex[0] = 8'h6E; ex[1] = 8'h51; ex[2] = 8'h82; ex[3] = 8'h01; ex[4] = f;
    ex[5] = 8'h6E ^ 8'h51 ^ 8'h82 ^ 8'h01 ^ f;
    nexp = (nwr >= 0) ? nwr + 1 : 6;
    chk(nw == nexp, "R2", "request byte count", nw, nexp);
    for (int i = 0; i < 6; i++) begin
      if (i < nw) chk(wb[i] == ex[i], "R2", $sformatf("request byte %0d", i), wb[i], ex[i]);
    end
    chk(!flags_bad, "R2", "request start/stop flags", {31'd0, flags_bad}, 0);
    if (nwr >= 0) begin
      chk(t_radr == -1 && nrd == 0, "R9", "no read after write NACK", nrd, 0);
      chk(abort_seen == (nwr < 5), "R9", "stop-only beat", {31'd0, abort_seen}, (nwr < 5));
    end else if (nra) begin
      chk(nrd == 0, "R9", "no read beats after address NACK", nrd, 0);
      chk(abort_seen, "R9", "stop-only beat after address NACK", {31'd0, abort_seen}, 1);
    end else begin
      chk((t_radr - t_acc) > gap, "R4", "gap before read", t_radr - t_acc, gap + 1);
      chk(nrd == 11, "R5", "read beat count", nrd, 11);
      chk(!last_bad, "R5", "last/stop only on final read", {31'd0, last_bad}, 0);
      chk(!abort_seen, "R5", "no stop-only beat", {31'd0, abort_seen}, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "R3", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err, "R1", "reset flags", {29'd0, busy, done, err}, 0);
    chk(!m_valid && !s_ready, "R1", "reset streams", {30'd0, m_valid, s_ready}, 0);
    chk(err_code == 3'd0 && max_val == 16'h0 && cur_val == 16'h0, "R1", "reset outputs",
        {max_val, cur_val}, 0);

    make_rep(8'h10, 8'h00, 8'h00, 16'd100, 16'd50); fix_sum();
    run_txn(8'h10, 8, -1, 1'b0, 1'b0, 3'd0, "R6", 1'b0);

    make_rep(8'h12, 8'h01, 8'h01, 16'hABCD, 16'h1234); fix_sum();
    run_txn(8'h12, 0, -1, 1'b0, 1'b0, 3'd0, "R7", 1'b0);

    make_rep(8'h10, 8'h00, 8'h00, 16'd77, 16'd7); fix_sum(); rep[10] = rep[10] ^ 8'h01;
    run_txn(8'h10, 3, -1, 1'b0, 1'b1, 3'd6, "R8", 1'b0);

    make_rep(8'h11, 8'h00, 8'h00, 16'd77, 16'd7); fix_sum();
    run_txn(8'h10, 3, -1, 1'b0, 1'b1, 3'd5, "R8", 1'b0);

    make_rep(8'h10, 8'h00, 8'h00, 16'd77, 16'd7); rep[1] = 8'h87; fix_sum();
    run_txn(8'h10, 3, -1, 1'b0, 1'b1, 3'd3, "R8", 1'b0);

    make_rep(8'h10, 8'h00, 8'h00, 16'd77, 16'd7); rep[2] = 8'h03; fix_sum();
    run_txn(8'h10, 3, -1, 1'b0, 1'b1, 3'd4, "R8", 1'b0);

    make_rep(8'h10, 8'h00, 8'h00, 16'd77, 16'd7); rep[0] = 8'h6A; fix_sum();
    run_txn(8'h10, 3, -1, 1'b0, 1'b1, 3'd2, "R8", 1'b0);

    make_rep(8'h10, 8'h00, 8'h00, 16'd77, 16'd7); rep[1] = 8'h87; rep[10] = 8'h00;
    run_txn(8'h10, 3, -1, 1'b0, 1'b1, 3'd3, "R8", 1'b0);

    make_rep(8'h10, 8'h00, 8'h00, 16'd1, 16'd1); fix_sum();
    run_txn(8'h10, 3, 2, 1'b0, 1'b1, 3'd1, "R9", 1'b0);
    run_txn(8'h10, 3, 5, 1'b0, 1'b1, 3'd1, "R9", 1'b0);
    run_txn(8'h10, 3, -1, 1'b1, 1'b1, 3'd1, "R9", 1'b0);

    make_rep(8'h14, 8'h00, 8'h02, 16'h00FF, 16'h0080); fix_sum();
    run_txn(8'h14, 40, -1, 1'b0, 1'b0, 3'd0, "R10", 1'b1);
    repeat (20) @(negedge clk);
    chk(!busy && !m_valid, "R10", "no second transaction from ignored go",
        {30'd0, busy, m_valid}, 0);

    make_rep(8'hE0, 8'h00, 8'h00, 16'hFFFF, 16'h0000); fix_sum();
    run_txn(8'hE0, 1, -1, 1'b0, 1'b0, 3'd0, "R6", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule